// File: doc/BRIEF.md
# GF(2^m) Matrix-Expansion Multiplier

This block multiplies two elements of a binary extension field GF(2^m) using only AND and XOR gates. Operand `b_i` is expanded into an m-by-m bit matrix. Row i of that matrix holds b times alpha^i, where alpha is the field's primitive element. The product is then the GF(2) product of the row vector `a_i` and that matrix. Each result bit is an XOR tree over the ANDs between `a_i` and one column of the matrix. No carry ever crosses a bit position, and the block uses no lookup tables.

Each step from one row to the next is a one-bit left shift. When the bit shifted out of the top is 1, the reduction taps are XORed in; the taps are the low m bits of the primitive polynomial. The field width `M` and the polynomial `POLY` are parameters. The defaults are m = 8 with polynomial 0x11D, and the block also builds for wider fields such as m = 11.

The datapath is a two-stage pipeline. It accepts one operand pair per cycle and presents each product with a valid strobe two cycles after its input strobe.

Top module: `gf_mul_mx`

## Requirements
- R1: With the default configuration (M = 8, POLY = 0x11D), for a valid input pair (a, b), `c_o` equals the carry-less product a·b reduced modulo POLY. This holds for all 65,536 pairs.
- R2: With M = 11 and POLY = 0x805, the product is reduced modulo that polynomial and is correct for arbitrary operand pairs.
- R3: If either operand of a valid pair is zero, the corresponding `c_o` is zero.
- R4: If either operand of a valid pair equals 1, `c_o` equals the other operand unchanged.
- R5: `out_valid_o` is asserted in the cycle exactly two clock edges after the edge that sampled `in_valid_i` high, and is low otherwise. The `c_o` presented with it belongs to that input pair.
- R6: A new pair may be presented on every cycle. N back-to-back valid inputs yield N consecutive valid outputs, all correct.
- R7: While `rst_ni` is low, `out_valid_o` is low at once, whatever the state of `in_valid_i`. Pairs presented during reset never appear at the output.
- R8: Bit a[i] selects row b·alpha^i, with bit 0 as the least significant bit. So a = 0x02 gives b shifted left by one, with the taps XORed in when b's top bit is set. For the defaults, a = 0x02 and b = 0x80 give 0x1D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid_i | input | 1 | Operand pair on `a_i`/`b_i` is valid this cycle |
| a_i | input | M | Vector operand (selects matrix rows) |
| b_i | input | M | Operand expanded into the alpha-power matrix |
| out_valid_o | output | 1 | `c_o` carries a product this cycle |
| c_o | output | M | Field product |

## Verification
On every cycle, the assertions check the two-cycle relation between `in_valid_i` and `out_valid_o`. They also check the algebraic shortcuts: a zero operand gives zero, a unit operand returns the other operand, and a = 2 with b's top bit clear gives a plain shift. Full arithmetic correctness needs a reference model, so only the bench's sweeps can show it. The bench runs every 8-bit pair against a shift-and-XOR multiply followed by polynomial reduction, and random 11-bit pairs against the same reference. Only the bench's scenarios show the unbroken back-to-back stream and the effect of a reset in the middle of traffic.

// File: rtl/gf_mx_pkg.sv
`timescale 1ns/1ps
package gf_mx_pkg;
  // pipeline depth from operand strobe to product strobe
  localparam int unsigned PIPE_LAT = 2;

  // low m bits of a primitive polynomial are the reduction taps
  function automatic int unsigned poly_taps(int unsigned poly, int unsigned m);
    return poly & ((32'd1 << m) - 32'd1);
  endfunction
endpackage

// File: rtl/gf_alpha_step.sv
`timescale 1ns/1ps
module gf_alpha_step #(
  parameter int unsigned M    = 8,
  parameter int unsigned POLY = 'h11D
) (
  input  logic [M-1:0] row_i,
  output logic [M-1:0] row_o
);
  import gf_mx_pkg::*;
  localparam logic [M-1:0] TAPS = M'(poly_taps(POLY, M));

  always_comb begin
    row_o = {row_i[M-2:0], 1'b0};
    if (row_i[M-1]) row_o = row_o ^ TAPS;
  end
endmodule

// File: rtl/gf_mx_expand.sv
`timescale 1ns/1ps
module gf_mx_expand #(
  parameter int unsigned M    = 8,
  parameter int unsigned POLY = 'h11D
) (
  input  logic [M-1:0]        b_i,
  output logic [M-1:0][M-1:0] rows_o   // rows_o[i] = b * alpha^i
);
  logic [M-1:0] row_w [M];

  assign row_w[0] = b_i;

  for (genvar i = 1; i < M; i++) begin : g_step
    gf_alpha_step #(.M(M), .POLY(POLY)) u_step (
      .row_i(row_w[i-1]),
      .row_o(row_w[i])
    );
  end

  for (genvar i = 0; i < M; i++) begin : g_out
    assign rows_o[i] = row_w[i];
  end
endmodule

// File: rtl/gf_mx_reduce.sv
`timescale 1ns/1ps
module gf_mx_reduce #(
  parameter int unsigned M = 8
) (
  input  logic [M-1:0]        a_i,
  input  logic [M-1:0][M-1:0] rows_i,
  output logic [M-1:0]        c_o
);
  for (genvar j = 0; j < M; j++) begin : g_col
    logic [M-1:0] col;
    for (genvar i = 0; i < M; i++) begin : g_bit
      assign col[i] = rows_i[i][j];
    end
    // AND with the vector, XOR-tree over the column
    assign c_o[j] = ^(a_i & col);
  end
endmodule

// File: rtl/gf_mul_mx.sv
`timescale 1ns/1ps
module gf_mul_mx #(
  parameter int unsigned M    = 8,
  parameter int unsigned POLY = 'h11D
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         out_valid_o,
  output logic [M-1:0] c_o
);
  import gf_mx_pkg::*;

  logic [M-1:0][M-1:0] rows_d, rows_q;
  logic [M-1:0]        a_q;
  logic [M-1:0]        prod_d, prod_q;
  logic [PIPE_LAT-1:0] vld_q;

  gf_mx_expand #(.M(M), .POLY(POLY)) u_expand (
    .b_i   (b_i),
    .rows_o(rows_d)
  );

  // stage 1: matrix and vector
  always_ff @(posedge clk_i) begin
    if (in_valid_i) begin
      rows_q <= rows_d;
      a_q    <= a_i;
    end
  end

  gf_mx_reduce #(.M(M)) u_reduce (
    .a_i   (a_q),
    .rows_i(rows_q),
    .c_o   (prod_d)
  );

  // stage 2: product
  always_ff @(posedge clk_i) begin
    if (vld_q[0]) prod_q <= prod_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[PIPE_LAT-2:0], in_valid_i};
  end

  assign out_valid_o = vld_q[PIPE_LAT-1];
  assign c_o         = prod_q;
endmodule

// File: rtl/gf_mul_mx_chk.sv
`timescale 1ns/1ps
module gf_mul_mx_chk #(
  parameter int unsigned M = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic [M-1:0] a_i,
  input logic [M-1:0] b_i,
  input logic         out_valid_o,
  input logic [M-1:0] c_o
);
  localparam logic [M-1:0] ONE = M'(1);
  localparam logic [M-1:0] TWO = M'(2);

  logic [1:0] up_cnt;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          up_cnt <= '0;
    else if (up_cnt != 2) up_cnt <= up_cnt + 2'd1;
  end
  assign warm = (up_cnt == 2'd2);

  AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (out_valid_o == $past(in_valid_i, 2)));  // R5

  AST_ZERO_PROD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && out_valid_o && ($past(a_i, 2) == '0 || $past(b_i, 2) == '0))
      |-> (c_o == '0));  // R3

  AST_UNIT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && out_valid_o && $past(a_i, 2) == ONE) |-> (c_o == $past(b_i, 2)));  // R4

  AST_UNIT_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && out_valid_o && $past(b_i, 2) == ONE) |-> (c_o == $past(a_i, 2)));  // R4

  AST_ROW_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && out_valid_o && $past(a_i, 2) == TWO && !$past(b_i[M-1], 2))
      |-> (c_o == {$past(b_i[M-2:0], 2), 1'b0}));  // R8
endmodule

bind gf_mul_mx gf_mul_mx_chk #(.M(M)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .out_valid_o(out_valid_o),
  .c_o        (c_o)
);

// File: tb/sim_gf_mul_mx.sv
`timescale 1ns/1ps
module sim_gf_mul_mx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        v_i = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [10:0] a11 = '0, b11 = '0;
  logic        v8, v11;
  logic [7:0]  c8;
  logic [10:0] c11;

  gf_mul_mx #(.M(8), .POLY('h11D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v_i),
    .a_i(a8), .b_i(b8), .out_valid_o(v8), .c_o(c8));

  gf_mul_mx #(.M(11), .POLY('h805)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v_i),
    .a_i(a11), .b_i(b11), .out_valid_o(v11), .c_o(c11));

  int n_run = 0, n_fail = 0, pulses = 0;
  logic        hv  [2];
  logic [7:0]  e8  [2];
  logic [10:0] e11 [2];
  string       tg  [2];

  function automatic int unsigned ref_mul(int unsigned a, int unsigned b,
                                          int unsigned m, int unsigned poly);
    int unsigned p = 0;
    for (int i = 0; i < m; i++) if (a[i]) p = p ^ (b << i);
    for (int k = 2*m - 2; k >= m; k--) if (p[k]) p = p ^ (poly << (k - m));
    return p;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_hist();
    for (int i = 0; i < 2; i++) begin
      hv[i] = 1'b0; e8[i] = '0; e11[i] = '0; tg[i] = "R1";
    end
  endtask

  // check the pair issued two cycles ago, then drive the next one
  task automatic step(logic v, int unsigned x8, int unsigned y8,
                      int unsigned x11, int unsigned y11);
    @(negedge clk);
    chk("R5 valid m8", v8, hv[1]);
    chk("R5 valid m11", v11, hv[1]);
    if (v8) pulses++;
    if (hv[1]) begin
      chk(tg[1], c8, e8[1]);
      chk("R2", c11, e11[1]);
    end
    hv[1] = hv[0]; e8[1] = e8[0]; e11[1] = e11[0]; tg[1] = tg[0];
    hv[0] = v;
    e8[0]  = 8'(ref_mul(x8, y8, 8, 'h11D));
    e11[0] = 11'(ref_mul(x11, y11, 11, 'h805));
    if (x8 == 0 || y8 == 0)      tg[0] = "R3";
    else if (x8 == 1 || y8 == 1) tg[0] = "R4";
    else if (x8 == 2)            tg[0] = "R8";
    else                         tg[0] = "R1";
    v_i = v; a8 = 8'(x8); b8 = 8'(y8); a11 = 11'(x11); b11 = 11'(y11);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    clr_hist();
    repeat (3) @(negedge clk);
    chk("R7 reset m8", v8, 0);
    chk("R7 reset m11", v11, 0);
    rst_ni = 1'b1;

    // R8 directed: 0x02 * 0x80 = 0x1D under 0x11D
    chk("R8 ref", ref_mul(2, 'h80, 8, 'h11D), 'h1D);

    pulses = 0;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(1'b1, a, b, $urandom % 2048, $urandom % 2048);
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0);
    chk("R6 back-to-back count", pulses, 65536);

    // R7: reset in the middle of traffic
    step(1'b1, 3, 7, 5, 9);
    step(1'b1, 4, 6, 8, 10);
    @(negedge clk);
    rst_ni = 1'b0;
    v_i    = 1'b1;
    #1;
    chk("R7 async clear m8", v8, 0);
    chk("R7 async clear m11", v11, 0);
    @(negedge clk);
    chk("R7 held m8", v8, 0);
    rst_ni = 1'b1;
    v_i    = 1'b0;
    clr_hist();
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0);
    step(1'b1, 'h53, 'hCA, 'h400, 'h3);
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0);
    summary();
  end
endmodule